// File: doc/BRIEF.md
# Sleep-State Power Sequencer for a Memory Supply

This block is the digital core of a memory power controller that follows the platform's sleep signals. It watches three supply-health flags (standby 5 V above its reset threshold, 12 V above its reset threshold, gate-drive voltage above trip) and two active-low sleep requests: one for suspend-to-RAM and one for soft-off. From these it drives enables for the main switching regulator, the standby LDO and the termination LDO. It also drives a strobe that holds the error amplifier in reset, a reference ramp code for soft start, a blocking-switch control (a value bit that is always low plus an output enable, where a low enable means high impedance), a power-good comparator enable and the final power-good output.

A cold start, or any soft-off request, re-arms a lockout. Until the system is seen fully awake, suspend requests are ignored. Startup holds the error amplifier in reset for a fixed count of clock cycles and then ramps the reference over a second fixed count. Entering suspend moves the memory rail onto the standby LDO at once and turns the switcher off at the next phase boundary. Leaving suspend restores the switcher and the termination rail at once, but power-good checking stays off for a third fixed count. The sleep inputs pass through two-flop synchronizers. The health flags and the phase pulse are assumed to be synchronous to the clock already.

Top module: `pseq_ctrl`

## Requirements
- R1: While reset is held, and after its release with no start condition, every enable, `ea_rst`, `ref_short`, `pg_cmp_en` and `pgood` is low, `ss_code` is zero, and the blocking switch is driven low (`blk_oe`=1, `blk_drv`=0).
- R2: Startup from off begins only when both sleep inputs read high (awake) and all three health flags are high at the same time. A low `slp_s3_n` seen while off is ignored, and the block stays off.
- R3: Startup opens with `ea_rst` high for exactly RST_CYCLES (default 2048) consecutive cycles. During that time `sw_en` is low and `ss_code` is zero.
- R4: Soft start then lasts exactly SS_CYCLES (default 2048) cycles with `sw_en` and `vtt_en` high. `ss_code` starts at 0, never decreases and reaches all ones. The active state follows, with `pg_cmp_en` high.
- R5: `pgood` is high only when the block is active, `pg_cmp_en` is high and `pgood_in` is high. It follows `pgood_in` in that state.
- R6: When `slp_s3_n` falls while active, the termination LDO turns off, `ref_short` and `sby_en` go high, `blk_oe` goes high (switch driven low), and `pgood` and `pg_cmp_en` go low.
- R7: After suspend entry, `sw_en` stays high until a cycle with `phase_pulse` high and falls in the next cycle.
- R8: When `slp_s3_n` rises in suspend with `por_12v` high, `sw_en` and `vtt_en` go high and `sby_en`, `ref_short` and `blk_oe` go low. Without `por_12v` the block stays in suspend.
- R9: On suspend exit, `pg_cmp_en` rises exactly PG_CYCLES (default 2048) cycles after `sw_en` rises.
- R10: A low `slp_s5_n` from any state forces the off outputs of R1 and re-arms the lockout. With `slp_s5_n` high again and `slp_s3_n` low, the block stays off.
- R11: Loss of `por_5vsb` in any state, or loss of `por_12v` or `gate_ok` outside suspend, forces the off outputs of R1 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_5vsb | input | 1 | Standby 5 V above reset threshold |
| por_12v | input | 1 | 12 V rail above reset threshold |
| gate_ok | input | 1 | Gate-drive voltage above trip level |
| slp_s3_n | input | 1 | Suspend-to-RAM request, active low, asynchronous |
| slp_s5_n | input | 1 | Soft-off request, active low, asynchronous |
| phase_pulse | input | 1 | One-cycle pulse at a switching-period boundary |
| pgood_in | input | 1 | Raw power-good comparator result |
| sw_en | output | 1 | Main switching regulator enable |
| sby_en | output | 1 | Standby LDO enable |
| vtt_en | output | 1 | Termination LDO enable |
| ref_short | output | 1 | Short termination reference to its rail |
| ea_rst | output | 1 | Error-amplifier reset strobe |
| ss_code | output | RAMP_W | Reference ramp code |
| blk_drv | output | 1 | Blocking-switch drive value (always low) |
| blk_oe | output | 1 | Blocking-switch drive enable; low means high impedance |
| pg_cmp_en | output | 1 | Power-good comparator enable |
| pgood | output | 1 | Power-good output |

## Verification
The bound checker watches, on every cycle, the rules that hold at any moment. These are: the termination LDO and the reference short are never on together, the ramp is zero and the switcher is off during amplifier reset, the ramp never falls while the switcher stays on, and the switcher drops on the standby path only after a phase pulse. It also checks that power-good needs both its enable and its input, that a lost standby flag clears every enable, and that no amplifier-reset run exceeds its count. The exact lengths of the reset, ramp and power-good delay windows, the ramp's end points, the lockout after soft-off and the choice of when startup may begin can only be shown by the bench's scenarios.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

   typedef enum logic [2:0] {
      PS_OFF,
      PS_EARST,
      PS_SOFT,
      PS_ACTIVE,
      PS_SLPWAIT,
      PS_SLEEP,
      PS_WAKE
   } pseq_state_e;

   typedef enum logic [1:0] {
      CODE_ZERO,
      CODE_RAMP,
      CODE_FULL
   } code_mode_e;

   typedef struct packed {
      logic       sw_en;
      logic       sby_en;
      logic       vtt_en;
      logic       ref_short;
      logic       ea_rst;
      logic       blk_oe;
      logic       pg_cmp_en;
      code_mode_e code_mode;
   } pseq_out_t;

   // Moore decode of the sequencer state into rail controls.
   function automatic pseq_out_t pseq_decode(pseq_state_e s);
      pseq_out_t o;
      o = '{sw_en: 1'b0, sby_en: 1'b0, vtt_en: 1'b0, ref_short: 1'b0,
            ea_rst: 1'b0, blk_oe: 1'b1, pg_cmp_en: 1'b0, code_mode: CODE_ZERO};
      case (s)
         PS_EARST: begin
            o.ea_rst = 1'b1;
         end
         PS_SOFT: begin
            o.sw_en     = 1'b1;
            o.vtt_en    = 1'b1;
            o.blk_oe    = 1'b0;
            o.code_mode = CODE_RAMP;
         end
         PS_ACTIVE: begin
            o.sw_en     = 1'b1;
            o.vtt_en    = 1'b1;
            o.blk_oe    = 1'b0;
            o.pg_cmp_en = 1'b1;
            o.code_mode = CODE_FULL;
         end
         PS_SLPWAIT: begin
            o.sw_en     = 1'b1;
            o.sby_en    = 1'b1;
            o.ref_short = 1'b1;
            o.code_mode = CODE_FULL;
         end
         PS_SLEEP: begin
            o.sby_en    = 1'b1;
            o.ref_short = 1'b1;
            o.code_mode = CODE_FULL;
         end
         PS_WAKE: begin
            o.sw_en     = 1'b1;
            o.vtt_en    = 1'b1;
            o.blk_oe    = 1'b0;
            o.code_mode = CODE_FULL;
         end
         default: ;
      endcase
      return o;
   endfunction

endpackage

// File: rtl/pseq_sync.sv
module pseq_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pseq_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pseq_timer.sv
module pseq_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] last,
   output logic [CNT_W-1:0] cnt,
   output logic             done
);

   if (CNT_W < 2) begin : g_bad_width
      $error("pseq_timer: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end

   assign done = (cnt == last);

endmodule

// File: rtl/pseq_ramp.sv
module pseq_ramp #(
   parameter int SS_LOG2 = 11,
   parameter int RAMP_W  = 8
) (
   input  logic [SS_LOG2-1:0]      step,
   input  pseq_pkg::code_mode_e    mode,
   output logic [RAMP_W-1:0]       code
);
   import pseq_pkg::*;

   logic [RAMP_W-1:0] ramp_val;

   if (SS_LOG2 >= RAMP_W) begin : g_narrow
      localparam int SHIFT = SS_LOG2 - RAMP_W;
      assign ramp_val = RAMP_W'(step >> SHIFT);
   end else begin : g_wide
      localparam int PAD = RAMP_W - SS_LOG2;
      // Replicating the step MSB keeps the code monotonic and reaches all ones.
      assign ramp_val = {step, {PAD{step[SS_LOG2-1]}}};
   end

   always_comb begin
      case (mode)
         CODE_RAMP: code = ramp_val;
         CODE_FULL: code = '1;
         default:   code = '0;
      endcase
   end

endmodule

// File: rtl/pseq_ctrl.sv
module pseq_ctrl #(
   parameter int CNT_W       = 12,
   parameter int RST_CYCLES  = 2048,
   parameter int SS_CYCLES   = 2048,
   parameter int PG_CYCLES   = 2048,
   parameter int RAMP_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              por_5vsb,
   input  logic              por_12v,
   input  logic              gate_ok,
   input  logic              slp_s3_n,
   input  logic              slp_s5_n,
   input  logic              phase_pulse,
   input  logic              pgood_in,
   output logic              sw_en,
   output logic              sby_en,
   output logic              vtt_en,
   output logic              ref_short,
   output logic              ea_rst,
   output logic [RAMP_W-1:0] ss_code,
   output logic              blk_drv,
   output logic              blk_oe,
   output logic              pg_cmp_en,
   output logic              pgood
);
   import pseq_pkg::*;

   localparam int SS_LOG2 = $clog2(SS_CYCLES);
   localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RST_CYCLES - 1);
   localparam logic [CNT_W-1:0] SS_LAST  = CNT_W'(SS_CYCLES - 1);
   localparam logic [CNT_W-1:0] PG_LAST  = CNT_W'(PG_CYCLES - 1);

   if (RST_CYCLES < 2 || RST_CYCLES > (1 << CNT_W)) begin : g_bad_rst
      $error("pseq_ctrl: RST_CYCLES out of counter range");
   end
   if (PG_CYCLES < 2 || PG_CYCLES > (1 << CNT_W)) begin : g_bad_pg
      $error("pseq_ctrl: PG_CYCLES out of counter range");
   end
   if (SS_CYCLES < 2 || SS_CYCLES > (1 << CNT_W)
       || (1 << SS_LOG2) != SS_CYCLES) begin : g_bad_ss
      $error("pseq_ctrl: SS_CYCLES must be a power of two within counter range");
   end
   if (RAMP_W < 1) begin : g_bad_ramp
      $error("pseq_ctrl: RAMP_W must be positive");
   end

   // Sleep request synchronizers: bit 1 = soft-off, bit 0 = suspend.
   logic [1:0] slp_sync;
   logic       s3_awake;
   logic       s5_awake;

   pseq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({slp_s5_n, slp_s3_n}),
      .q    (slp_sync)
   );
   assign s3_awake = slp_sync[0];
   assign s5_awake = slp_sync[1];

   pseq_state_e      st_q;
   pseq_state_e      st_d;
   logic [CNT_W-1:0] tmr_cnt;
   logic [CNT_W-1:0] tmr_last;
   logic             tmr_done;
   logic             all_ok;
   pseq_out_t        ctl;

   assign all_ok = por_5vsb & por_12v & gate_ok;

   always_comb begin
      case (st_q)
         PS_EARST: tmr_last = RST_LAST;
         PS_SOFT:  tmr_last = SS_LAST;
         PS_WAKE:  tmr_last = PG_LAST;
         default:  tmr_last = '0;
      endcase
   end

   pseq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (st_d != st_q),
      .last (tmr_last),
      .cnt  (tmr_cnt),
      .done (tmr_done)
   );

   always_comb begin
      st_d = st_q;
      if (!s5_awake || !por_5vsb) begin
         st_d = PS_OFF;
      end else begin
         case (st_q)
            PS_OFF: begin
               if (all_ok && s3_awake) st_d = PS_EARST;
            end
            PS_EARST: begin
               if (!all_ok)       st_d = PS_OFF;
               else if (tmr_done) st_d = PS_SOFT;
            end
            PS_SOFT: begin
               if (!all_ok)       st_d = PS_OFF;
               else if (tmr_done) st_d = PS_ACTIVE;
            end
            PS_ACTIVE: begin
               if (!all_ok)       st_d = PS_OFF;
               else if (!s3_awake) st_d = PS_SLPWAIT;
            end
            PS_SLPWAIT: begin
               if (phase_pulse)   st_d = PS_SLEEP;
            end
            PS_SLEEP: begin
               if (s3_awake && por_12v) st_d = PS_WAKE;
            end
            PS_WAKE: begin
               if (!all_ok)        st_d = PS_OFF;
               else if (!s3_awake) st_d = PS_SLPWAIT;
               else if (tmr_done)  st_d = PS_ACTIVE;
            end
            default: st_d = PS_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= PS_OFF;
      else        st_q <= st_d;
   end

   assign ctl = pseq_decode(st_q);

   pseq_ramp #(.SS_LOG2(SS_LOG2), .RAMP_W(RAMP_W)) u_ramp (
      .step(tmr_cnt[SS_LOG2-1:0]),
      .mode(ctl.code_mode),
      .code(ss_code)
   );

   assign sw_en     = ctl.sw_en;
   assign sby_en    = ctl.sby_en;
   assign vtt_en    = ctl.vtt_en;
   assign ref_short = ctl.ref_short;
   assign ea_rst    = ctl.ea_rst;
   assign blk_oe    = ctl.blk_oe;
   assign blk_drv   = 1'b0;
   assign pg_cmp_en = ctl.pg_cmp_en;
   assign pgood     = (st_q == PS_ACTIVE) & ctl.pg_cmp_en & pgood_in;

endmodule

// File: rtl/pseq_ctrl_chk.sv
module pseq_ctrl_chk #(
   parameter int CNT_W      = 12,
   parameter int RST_CYCLES = 2048,
   parameter int RAMP_W     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              por_5vsb,
   input logic              phase_pulse,
   input logic              pgood_in,
   input logic              sw_en,
   input logic              sby_en,
   input logic              vtt_en,
   input logic              ref_short,
   input logic              ea_rst,
   input logic [RAMP_W-1:0] ss_code,
   input logic              blk_oe,
   input logic              pg_cmp_en,
   input logic              pgood
);

   logic [CNT_W:0] ea_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ea_run <= '0;
      else if (ea_rst) ea_run <= ea_run + 1'b1;
      else             ea_run <= '0;
   end

   a_r3_ea_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ea_rst |-> (!sw_en && ss_code == '0));

   a_r3_ea_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      ea_run <= (CNT_W+1)'(RST_CYCLES));

   a_r4_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && $past(sw_en)) |-> (ss_code >= $past(ss_code)));

   a_r5_pgood_gated: assert property (@(posedge clk) disable iff (!rst_n)
      pgood |-> (pg_cmp_en && pgood_in && !sby_en));

   a_r6_vtt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(vtt_en && ref_short));

   a_r6_entry_set: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(vtt_en) && sby_en) |-> (ref_short && blk_oe && !pgood && !pg_cmp_en));

   a_r7_phase_off: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sw_en) && sby_en) |-> $past(phase_pulse));

   a_r9_cmp_with_sw: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pg_cmp_en) |-> (sw_en && vtt_en && !sby_en));

   a_r11_sby_loss: assert property (@(posedge clk) disable iff (!rst_n)
      !por_5vsb |=> (!sw_en && !vtt_en && !sby_en && !pgood));

endmodule

bind pseq_ctrl pseq_ctrl_chk #(
   .CNT_W     (CNT_W),
   .RST_CYCLES(RST_CYCLES),
   .RAMP_W    (RAMP_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .por_5vsb   (por_5vsb),
   .phase_pulse(phase_pulse),
   .pgood_in   (pgood_in),
   .sw_en      (sw_en),
   .sby_en     (sby_en),
   .vtt_en     (vtt_en),
   .ref_short  (ref_short),
   .ea_rst     (ea_rst),
   .ss_code    (ss_code),
   .blk_oe     (blk_oe),
   .pg_cmp_en  (pg_cmp_en),
   .pgood      (pgood)
);

// File: tb/tb_pseq_ctrl.sv
module tb_pseq_ctrl;

   localparam int RAMP_W = 8;
   localparam int NCYC   = 2048;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic por_5vsb = 1'b0, por_12v = 1'b0, gate_ok = 1'b0;
   logic slp_s3_n = 1'b0, slp_s5_n = 1'b0;
   logic phase_pulse = 1'b0, pgood_in = 1'b0;
   logic sw_en, sby_en, vtt_en, ref_short, ea_rst, blk_drv, blk_oe, pg_cmp_en, pgood;
   logic [RAMP_W-1:0] ss_code;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   pseq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .por_5vsb(por_5vsb), .por_12v(por_12v),
      .gate_ok(gate_ok), .slp_s3_n(slp_s3_n), .slp_s5_n(slp_s5_n),
      .phase_pulse(phase_pulse), .pgood_in(pgood_in), .sw_en(sw_en),
      .sby_en(sby_en), .vtt_en(vtt_en), .ref_short(ref_short), .ea_rst(ea_rst),
      .ss_code(ss_code), .blk_drv(blk_drv), .blk_oe(blk_oe),
      .pg_cmp_en(pg_cmp_en), .pgood(pgood)
   );

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   // Packs the off-state outputs: {sw,sby,vtt,short,ea,oe,drv,cmp,pg}; off = 9'b000001000
   function automatic int off_word();
      return {23'd0, sw_en, sby_en, vtt_en, ref_short, ea_rst, blk_oe, blk_drv, pg_cmp_en, pgood};
   endfunction

   // Vector table: {por_5vsb, por_12v, gate_ok, slp_s3_n, slp_s5_n, expect_start}
   localparam logic [5:0] VEC [8] = '{
      6'b111111, 6'b011110, 6'b101110, 6'b110110,
      6'b111010, 6'b111100, 6'b111000, 6'b000110
   };

   initial begin
      #(150000 * 5);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      int prev;
      int first;
      int mono_ok;

      // R1: reset state
      tick(3);
      check("R1 off outputs in reset", off_word(), 9'b000001000);
      check("R1 ramp zero in reset", int'(ss_code), 0);
      rst_n = 1'b1;
      tick(5);
      check("R1 off outputs after reset", off_word(), 9'b000001000);

      // R2: start conditions from the vector table
      foreach (VEC[i]) begin
         rst_n = 1'b0;
         {por_5vsb, por_12v, gate_ok, slp_s3_n, slp_s5_n} = VEC[i][5:1];
         tick(2);
         rst_n = 1'b1;
         tick(10);
         check($sformatf("R2 start vector %0d", i), int'(ea_rst), int'(VEC[i][0]));
         if (!VEC[i][0]) check($sformatf("R2 stays off vector %0d", i), off_word(), 9'b000001000);
      end

      // Cold start: R3 amplifier reset length
      rst_n = 1'b0;
      {por_5vsb, por_12v, gate_ok, slp_s3_n, slp_s5_n} = 5'b11111;
      pgood_in = 1'b1;
      tick(2);
      rst_n = 1'b1;
      n = 0;
      while (!ea_rst && n < 20) begin tick(1); n++; end
      n = 0;
      while (ea_rst && n < 5000) begin
         if (sw_en || ss_code != 0) check("R3 quiet during reset", 1, 0);
         tick(1); n++;
      end
      check("R3 ea_rst length", n, NCYC);

      // R4: soft start
      n = 0; first = int'(ss_code); prev = first; mono_ok = 1;
      while (sw_en && !pg_cmp_en && n < 5000) begin
         if (!vtt_en) mono_ok = 0;
         if (int'(ss_code) < prev) mono_ok = 0;
         prev = int'(ss_code);
         tick(1); n++;
      end
      check("R4 soft start length", n, NCYC);
      check("R4 ramp starts at zero", first, 0);
      check("R4 ramp last value", prev, 255);
      check("R4 ramp monotonic with vtt on", mono_ok, 1);
      check("R4 active cmp enable", int'(pg_cmp_en), 1);
      check("R4 blk high impedance", int'(blk_oe), 0);

      // R5: pgood follows input in active
      check("R5 pgood high", int'(pgood), 1);
      pgood_in = 1'b0; tick(1);
      check("R5 pgood low with input low", int'(pgood), 0);
      pgood_in = 1'b1; tick(1);

      // R6: suspend entry
      slp_s3_n = 1'b0;
      tick(5);
      check("R6 entry outputs {sby,vtt,short,oe,drv,cmp,pg}",
            {sby_en, vtt_en, ref_short, blk_oe, blk_drv, pg_cmp_en, pgood}, 7'b1011000);
      // R7: switcher waits for phase pulse
      check("R7 sw held before phase", int'(sw_en), 1);
      tick(10);
      check("R7 sw still held", int'(sw_en), 1);
      phase_pulse = 1'b1; tick(1); phase_pulse = 1'b0;
      check("R7 sw off after phase", int'(sw_en), 0);

      // R8: wake blocked without 12V
      por_12v = 1'b0; gate_ok = 1'b0;
      tick(3);
      slp_s3_n = 1'b1;
      tick(8);
      check("R8 stays asleep without 12V", {sw_en, sby_en}, 2'b01);
      por_12v = 1'b1; gate_ok = 1'b1;
      n = 0;
      while (!sw_en && n < 10) begin tick(1); n++; end
      check("R8 wake outputs {sw,sby,vtt,short,oe}",
            {sw_en, sby_en, vtt_en, ref_short, blk_oe}, 5'b10100);
      // R9: power-good delay
      n = 0;
      while (sw_en && !pg_cmp_en && n < 5000) begin
         if (pgood) check("R9 pgood during delay", 1, 0);
         tick(1); n++;
      end
      check("R9 cmp delay length", n, NCYC);
      check("R9 pgood after delay", int'(pgood), 1);

      // R10: soft-off and lockout
      slp_s5_n = 1'b0;
      tick(5);
      check("R10 off after soft-off", off_word(), 9'b000001000);
      slp_s3_n = 1'b0;
      slp_s5_n = 1'b1;
      tick(12);
      check("R10 lockout ignores suspend", off_word(), 9'b000001000);
      slp_s3_n = 1'b1;
      tick(5);
      check("R10 restart through amp reset", int'(ea_rst), 1);

      // R11: rail loss during startup
      por_12v = 1'b0;
      tick(1);
      check("R11 off after 12V loss", off_word(), 9'b000001000);
      por_12v = 1'b1;
      tick(5);
      por_5vsb = 1'b0;
      tick(1);
      check("R11 off after standby loss", off_word(), 9'b000001000);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule